// File: doc/BRIEF.md
# CAN Command Register Controller

This block sits between the CPU write path and the transmit engine, the receive FIFO and the interrupt logic of a CAN controller. The CPU writes one byte in a single cycle. Each bit written as 1 starts one action. The actions are: request a transmission, request a transmission that is also received back (self-reception), cancel a request that has not yet been picked up, release the current receive buffer, and clear the data-overrun flag. The register cannot be read back.

The block keeps four pieces of state. The first is the outstanding-transmit flag, together with its self-reception qualifier. The second is the transmission-complete status, which lets software tell a sent frame from an aborted one. The third is the data-overrun status. The fourth is the receive-interrupt line. After a buffer release, the receive interrupt is held off for a parameterised number of cycles, so the FIFO can present its next message before the line is evaluated again.

Top module: `can_cmd_ctrl`

## Requirements
- R1: Bit positions in `cmd_wdata` are: 0 send request, 1 abort, 2 release buffer, 3 clear overrun, 4 self-reception request, and 7..5 reserved. A bit written as 0 has no effect, and reserved bits have no effect. `cmd_rdata` is always zero, and all status outputs are 0 after reset.
- R2: A write with bit 0 set and bit 1 clear raises `tx_pend` one cycle later, with `tx_self` low. A `tx_start` pulse clears `tx_pend` on the next edge.
- R3: A write with bit 4 set and bit 1 clear raises `tx_pend` with `tx_self` high one cycle later.
- R4: A write with bit 1 set clears a pending request that has not started. If the request has already started, or starts in the same cycle, the transmission goes on, and its later `tx_done` still sets `tx_cmpl`.
- R5: When bit 0 and bit 1 are written together, the abort wins and no new request is accepted. `tx_cmpl` is left unchanged.
- R6: `tx_cmpl` is set one cycle after `tx_done` and cleared when a new request is accepted. A successful abort leaves it clear. `tx_irq` is a one-cycle pulse, one cycle after `tx_done`.
- R7: `ovr_event` sets `ovr_sts` one cycle later. `ovr_irq` pulses only when `ovr_sts` was clear. A write with bit 3 set clears `ovr_sts`, but an `ovr_event` in the same cycle keeps it set.
- R8: A write with bit 2 set while `rx_avail` is high gives a one-cycle `rx_release` pulse on the next cycle. With `rx_avail` low, no pulse is given.
- R9: Outside a hold-off, `rx_irq` is the registered value of `rx_avail && (rx_hipri || rx_bytes > rx_level)`.
- R10: After a release, `rx_irq` stays low for HOLD_CYC+1 cycles after the write edge. This gives at least HOLD_CYC cycles (default 2) after the `rx_release` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | One-cycle command write strobe |
| cmd_wdata | input | 8 | Command byte |
| cmd_rdata | output | 8 | Read value of the register, always zero |
| tx_start | input | 1 | Transmit engine has picked up the pending request |
| tx_done | input | 1 | Transmit engine finished a frame successfully |
| tx_pend | output | 1 | A request is waiting for the transmit engine |
| tx_self | output | 1 | The pending request is a self-reception request |
| tx_cmpl | output | 1 | Transmission-complete status |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_avail | input | 1 | The FIFO holds at least one message |
| rx_hipri | input | 1 | A high-priority message is in the FIFO |
| rx_bytes | input | CNT_W | Bytes available in the FIFO |
| rx_level | input | CNT_W | Programmed receive-interrupt level |
| rx_release | output | 1 | Pulse that frees the current FIFO message |
| rx_irq | output | 1 | Receive interrupt |
| ovr_event | input | 1 | The FIFO detected a data overrun |
| ovr_sts | output | 1 | Data-overrun status |
| ovr_irq | output | 1 | Data-overrun interrupt pulse |

## Verification
The assertions assume that the transmit engine pulses `tx_start` only while a request is pending, and that `cmd_we`, `tx_start`, `tx_done` and `ovr_event` are one-cycle pulses, clean from reset. The bench changes inputs only on falling edges. It raises each strobe for exactly one cycle, and it orders engine handshakes after a request has been seen. The FIFO-side levels are held steady across each checked window, so the hold-off and qualification checks see a settled state.

// File: rtl/can_cmd_pkg.sv
package can_cmd_pkg;
  localparam int CMD_W  = 8;
  localparam int B_SEND = 0;
  localparam int B_ABRT = 1;
  localparam int B_REL  = 2;
  localparam int B_CLRO = 3;
  localparam int B_SELF = 4;

  typedef struct packed {
    logic send;
    logic abrt;
    logic rel;
    logic clro;
    logic self_rx;
  } cmd_t;
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_cmd_pkg::*;
(
  input  logic             we,
  input  logic [CMD_W-1:0] wdata,
  output cmd_t             cmd
);
  logic unused_rsvd;
  assign unused_rsvd = |wdata[CMD_W-1:B_SELF+1];

  always_comb begin
    cmd.send    = we & wdata[B_SEND];
    cmd.abrt    = we & wdata[B_ABRT];
    cmd.rel     = we & wdata[B_REL];
    cmd.clro    = we & wdata[B_CLRO];
    cmd.self_rx = we & wdata[B_SELF];
  end
endmodule

// File: rtl/can_cmd_tx.sv
module can_cmd_tx
  import can_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  logic tx_start,
  input  logic tx_done,
  output logic tx_pend,
  output logic tx_self,
  output logic tx_cmpl,
  output logic tx_irq
);
  logic accept;
  logic pend_d, self_d, cmpl_d;
  logic pend_q, self_q, cmpl_q, irq_q;

  always_comb begin
    accept = (cmd.send | cmd.self_rx) & ~cmd.abrt;
    pend_d = pend_q;
    self_d = self_q;
    cmpl_d = cmpl_q;
    if (accept) begin
      pend_d = 1'b1;
      self_d = cmd.self_rx;
    end else if (tx_start | cmd.abrt) begin
      pend_d = 1'b0;
    end
    if (accept) begin
      cmpl_d = 1'b0;
    end else if (tx_done) begin
      cmpl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      self_q <= 1'b0;
      cmpl_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      self_q <= self_d;
      cmpl_q <= cmpl_d;
      irq_q  <= tx_done;
    end
  end

  assign tx_pend = pend_q;
  assign tx_self = self_q;
  assign tx_cmpl = cmpl_q;
  assign tx_irq  = irq_q;
endmodule

// File: rtl/can_cmd_rx.sv
module can_cmd_rx
  import can_cmd_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_t             cmd,
  input  logic             rx_avail,
  input  logic             rx_hipri,
  input  logic [CNT_W-1:0] rx_bytes,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             ovr_event,
  output logic             rx_release,
  output logic             rx_irq,
  output logic             ovr_sts,
  output logic             ovr_irq
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic              rel_go, qualify, hold_act;
  logic [HOLD_W-1:0] hold_d, hold_q;
  logic              irq_d, irq_q, rel_q;
  logic              ovr_d, ovr_q, oirq_q;

  always_comb begin
    rel_go   = cmd.rel & rx_avail;
    qualify  = rx_avail & (rx_hipri | (rx_bytes > rx_level));
    hold_act = rel_go | (hold_q != '0);
    if (rel_go) begin
      hold_d = HOLD_W'(HOLD_CYC);
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end else begin
      hold_d = hold_q;
    end
    irq_d = hold_act ? 1'b0 : qualify;
    if (ovr_event) begin
      ovr_d = 1'b1;
    end else if (cmd.clro) begin
      ovr_d = 1'b0;
    end else begin
      ovr_d = ovr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      irq_q  <= 1'b0;
      rel_q  <= 1'b0;
      ovr_q  <= 1'b0;
      oirq_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      irq_q  <= irq_d;
      rel_q  <= rel_go;
      ovr_q  <= ovr_d;
      oirq_q <= ovr_event & ~ovr_q;
    end
  end

  assign rx_release = rel_q;
  assign rx_irq     = irq_q;
  assign ovr_sts    = ovr_q;
  assign ovr_irq    = oirq_q;
endmodule

// File: rtl/can_cmd_ctrl.sv
module can_cmd_ctrl
  import can_cmd_pkg::*;
#(
  parameter int CNT_W    = 7,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_wdata,
  output logic [7:0]       cmd_rdata,
  input  logic             tx_start,
  input  logic             tx_done,
  output logic             tx_pend,
  output logic             tx_self,
  output logic             tx_cmpl,
  output logic             tx_irq,
  input  logic             rx_avail,
  input  logic             rx_hipri,
  input  logic [CNT_W-1:0] rx_bytes,
  input  logic [CNT_W-1:0] rx_level,
  output logic             rx_release,
  output logic             rx_irq,
  input  logic             ovr_event,
  output logic             ovr_sts,
  output logic             ovr_irq
);
  cmd_t cmd;

  assign cmd_rdata = '0;

  can_cmd_decode u_dec (
    .we    (cmd_we),
    .wdata (cmd_wdata),
    .cmd   (cmd)
  );

  can_cmd_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .tx_start (tx_start),
    .tx_done  (tx_done),
    .tx_pend  (tx_pend),
    .tx_self  (tx_self),
    .tx_cmpl  (tx_cmpl),
    .tx_irq   (tx_irq)
  );

  can_cmd_rx #(
    .CNT_W    (CNT_W),
    .HOLD_CYC (HOLD_CYC)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .rx_avail   (rx_avail),
    .rx_hipri   (rx_hipri),
    .rx_bytes   (rx_bytes),
    .rx_level   (rx_level),
    .ovr_event  (ovr_event),
    .rx_release (rx_release),
    .rx_irq     (rx_irq),
    .ovr_sts    (ovr_sts),
    .ovr_irq    (ovr_irq)
  );
endmodule

// File: rtl/can_cmd_chk.sv
module can_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] cmd_wdata,
  input logic       tx_start,
  input logic       tx_done,
  input logic       tx_pend,
  input logic       tx_self,
  input logic       tx_cmpl,
  input logic       rx_avail,
  input logic       rx_release,
  input logic       rx_irq,
  input logic       ovr_sts,
  input logic       ovr_irq
);
  AST_REQ_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[0] && !cmd_wdata[1] |=> tx_pend); // R2
  AST_SELF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[4] && !cmd_wdata[1] |=> tx_pend && tx_self); // R3
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[1] |=> !tx_pend); // R4
  AST_ABORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_wdata[0] && cmd_wdata[1] && !tx_done |=> $stable(tx_cmpl)); // R5
  AST_CMPL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !(cmd_we && (cmd_wdata[0] || cmd_wdata[4]) && !cmd_wdata[1]) |=> tx_cmpl); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && !(cmd_we && (cmd_wdata[0] || cmd_wdata[4])) |=> !tx_pend); // R2
  AST_OVR_IRQ_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> ovr_sts && !$past(ovr_sts)); // R7
  AST_REL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release |-> $past(cmd_we && cmd_wdata[2] && rx_avail)); // R8
  AST_HOLD_REL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release |-> !rx_irq); // R10
  AST_HOLD_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    rx_release |=> !rx_irq); // R10
endmodule

bind can_cmd_ctrl can_cmd_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_we     (cmd_we),
  .cmd_wdata  (cmd_wdata),
  .tx_start   (tx_start),
  .tx_done    (tx_done),
  .tx_pend    (tx_pend),
  .tx_self    (tx_self),
  .tx_cmpl    (tx_cmpl),
  .rx_avail   (rx_avail),
  .rx_release (rx_release),
  .rx_irq     (rx_irq),
  .ovr_sts    (ovr_sts),
  .ovr_irq    (ovr_irq)
);

// File: tb/can_cmd_ctrl_bench.sv
module can_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 7;
  localparam int NVEC       = 8;
  // {expected irq, level, bytes, hipri, avail}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 7'd2,   7'd9,   1'b1, 1'b0},
    {1'b1, 7'd5,   7'd0,   1'b1, 1'b1},
    {1'b1, 7'd5,   7'd6,   1'b0, 1'b1},
    {1'b0, 7'd5,   7'd5,   1'b0, 1'b1},
    {1'b0, 7'd5,   7'd4,   1'b0, 1'b1},
    {1'b1, 7'd126, 7'd127, 1'b0, 1'b1},
    {1'b0, 7'd0,   7'd0,   1'b0, 1'b1},
    {1'b0, 7'd1,   7'd10,  1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] cmd_rdata;
  logic tx_start = 1'b0, tx_done = 1'b0;
  logic tx_pend, tx_self, tx_cmpl, tx_irq;
  logic rx_avail = 1'b0, rx_hipri = 1'b0;
  logic [CNT_W-1:0] rx_bytes = '0, rx_level = '0;
  logic rx_release, rx_irq;
  logic ovr_event = 1'b0;
  logic ovr_sts, ovr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_cmd_ctrl #(.CNT_W(CNT_W), .HOLD_CYC(2)) u_can_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .tx_start(tx_start), .tx_done(tx_done),
    .tx_pend(tx_pend), .tx_self(tx_self), .tx_cmpl(tx_cmpl), .tx_irq(tx_irq),
    .rx_avail(rx_avail), .rx_hipri(rx_hipri), .rx_bytes(rx_bytes),
    .rx_level(rx_level), .rx_release(rx_release), .rx_irq(rx_irq),
    .ovr_event(ovr_event), .ovr_sts(ovr_sts), .ovr_irq(ovr_irq)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmd_we = 1'b0; cmd_wdata = '0;
    tx_start = 1'b0; tx_done = 1'b0; ovr_event = 1'b0;
  endtask

  task automatic wr(logic [7:0] d);
    cmd_we = 1'b1; cmd_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pend", tx_pend, 0);
    check("R1 reset cmpl/ovr/irq", {tx_cmpl, ovr_sts, rx_irq, tx_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      rx_avail = VEC[i][0];
      rx_hipri = VEC[i][1];
      rx_bytes = VEC[i][8:2];
      rx_level = VEC[i][15:9];
      tick();
      check($sformatf("R9 vector %0d", i), rx_irq, VEC[i][16]);
    end
    rx_avail = 1'b0;

    // R1 reserved bits and zero writes
    wr(8'hE0); tick();
    check("R1 reserved no pend", tx_pend, 0);
    check("R1 reserved no release", rx_release, 0);
    wr(8'h00); tick();
    check("R1 zero write no effect", {tx_pend, ovr_sts}, 0);
    check("R1 rdata zero", cmd_rdata, 0);

    // R2
    wr(8'h01); tick();
    check("R2 pend set", tx_pend, 1);
    check("R2 self low", tx_self, 0);
    tx_start = 1'b1; tick();
    check("R2 start clears pend", tx_pend, 0);
    // R4 abort after start has no effect on the running frame
    wr(8'h02); tick();
    tx_done = 1'b1; tick();
    check("R4 started frame completes", tx_cmpl, 1);
    check("R6 tx_irq pulse", tx_irq, 1);
    tick();
    check("R6 tx_irq one cycle", tx_irq, 0);

    // R6 new request clears complete; abort keeps it clear
    wr(8'h01); tick();
    check("R6 accept clears cmpl", tx_cmpl, 0);
    wr(8'h02); tick();
    check("R4 abort cancels pending", tx_pend, 0);
    check("R6 abort leaves cmpl clear", tx_cmpl, 0);

    // R4 abort in the same cycle as start
    wr(8'h01); tick();
    wr(8'h02); tx_start = 1'b1; tick();
    check("R4 pend clear after start+abort", tx_pend, 0);
    tx_done = 1'b1; tick();
    check("R4 frame still completes", tx_cmpl, 1);

    // R5 abort and request together
    wr(8'h03); tick();
    check("R5 no request accepted", tx_pend, 0);
    check("R5 cmpl unchanged", tx_cmpl, 1);

    // R3 self-reception
    wr(8'h10); tick();
    check("R3 pend", tx_pend, 1);
    check("R3 self flag", tx_self, 1);
    check("R6 cmpl cleared by self request", tx_cmpl, 0);

    // R7 overrun
    ovr_event = 1'b1; tick();
    check("R7 sts set", ovr_sts, 1);
    check("R7 irq first", ovr_irq, 1);
    ovr_event = 1'b1; tick();
    check("R7 no repeat irq", ovr_irq, 0);
    wr(8'h08); tick();
    check("R7 clear", ovr_sts, 0);
    wr(8'h08); ovr_event = 1'b1; tick();
    check("R7 event beats clear", ovr_sts, 1);

    // R8 / R10 release and hold-off
    rx_avail = 1'b1; rx_hipri = 1'b0; rx_bytes = 7'd5; rx_level = 7'd2;
    tick();
    check("R9 irq before release", rx_irq, 1);
    wr(8'h04); tick();
    check("R8 release pulse", rx_release, 1);
    check("R10 irq low at release", rx_irq, 0);
    tick();
    check("R8 release one cycle", rx_release, 0);
    check("R10 hold 1", rx_irq, 0);
    tick();
    check("R10 hold 2", rx_irq, 0);
    tick();
    check("R10 irq returns", rx_irq, 1);
    rx_avail = 1'b0; tick();
    wr(8'h04); tick();
    check("R8 no release when empty", rx_release, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule